// File: doc/BRIEF.md
# HI/LO Multiply-Accumulate Unit

This block multiplies two 32-bit operands and folds the 64-bit product into an internal accumulator split into a high word (HI) and a low word (LO). Four operations are offered: a plain multiply, a negated multiply (zero minus the product), multiply-accumulate and multiply-subtract. Each runs in signed or unsigned form. All arithmetic wraps modulo 2^64.

A caller raises `start` for one cycle with the operands, an operation code, a signedness bit and a bit that picks which half of the new accumulator comes back on `result`. One clock later HI, LO and `result` are updated together, and `result_valid` pulses for that one cycle. Separate write ports load HI or LO directly. Both words can be read at any time on `hi_out` and `lo_out`.

Top module: `hilo_mac_top`

## Requirements
- R1: After synchronous reset, `hi_out`, `lo_out` and `result` are zero and `result_valid` is low.
- R2: With `is_signed`=1 both operands are sign-extended to 64 bits before multiplying. With `is_signed`=0 they are zero-extended.
- R3: Operation code 0 (multiply) loads HI:LO with the product.
- R4: Operation code 1 (negated multiply) loads HI:LO with 0 minus the product, modulo 2^64.
- R5: Operation code 2 (accumulate) loads HI:LO with the old {HI,LO} plus the product, modulo 2^64.
- R6: Operation code 3 (subtract) loads HI:LO with the old {HI,LO} minus the product, modulo 2^64.
- R7: After an operation, `lo_out` holds bits 31:0 of the 64-bit result and `hi_out` holds bits 63:32. Both are visible one clock after `start`.
- R8: When `want_hi`=1, `result` carries the new HI. When `want_hi`=0, it carries the new LO. `result` keeps that value until the next accepted operation.
- R9: `result_valid` is high for exactly the one cycle that follows an accepted `start`, and is low in every other cycle.
- R10: When no operation is accepted, `hi_wr_en` loads `hi_wr_data` into HI and `lo_wr_en` loads `lo_wr_data` into LO at the clock edge. Each write acts independently of the other.
- R11: When a direct write and an accepted operation fall in the same cycle, the operation result is stored and the write is dropped.
- R12: A `start` with operation codes 4 to 7 is ignored. HI, LO and `result` keep their values, no `result_valid` pulse follows, and direct writes in that cycle still apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch one operation this cycle |
| op | input | 3 | Operation code (0 mul, 1 negated mul, 2 accumulate, 3 subtract) |
| is_signed | input | 1 | 1 = signed operands, 0 = unsigned |
| want_hi | input | 1 | 1 = return new HI, 0 = return new LO |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| hi_wr_en | input | 1 | Direct write enable for HI |
| hi_wr_data | input | 32 | Data for a direct HI write |
| lo_wr_en | input | 1 | Direct write enable for LO |
| lo_wr_data | input | 32 | Data for a direct LO write |
| hi_out | output | 32 | Current HI word |
| lo_out | output | 32 | Current LO word |
| result | output | 32 | Selected half of the last operation result |
| result_valid | output | 1 | One-cycle pulse marking a fresh result |

## Verification
The bench goes after operand extension. The case 0xFFFFFFFF times 0xFFFFFFFF gives different answers signed and unsigned, so a design that extends the wrong way returns 0x00000000_00000001 where 0xFFFFFFFE_00000001 is expected, or the reverse. It drives accumulate across the 2^64 wrap and subtract below zero, where a lost carry or a missing borrow shows up in HI. Direct writes are placed in the same cycle as an operation and in the same cycle as a reserved code. A design with the priority backwards keeps the written word, and one that decodes the reserved codes loosely corrupts HI:LO or pulses `result_valid`. A long random run is then compared cycle by cycle with a behavioural model.

// File: rtl/hilo_pkg.sv
package hilo_pkg;

    localparam int DATA_W = 32;
    localparam int ACC_W  = 2 * DATA_W;

    typedef enum logic [2:0] {
        OPK_MUL  = 3'd0,
        OPK_NMUL = 3'd1,
        OPK_MADD = 3'd2,
        OPK_MSUB = 3'd3
    } op_kind_e;

    typedef struct packed {
        logic [2:0]        op;
        logic              is_signed;
        logic              want_hi;
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
    } mac_req_t;

    function automatic logic op_is_known(input logic [2:0] code);
        return code[2] == 1'b0;
    endfunction

endpackage

// File: rtl/hilo_product.sv
module hilo_product
    import hilo_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           is_signed,
    output logic [2*W-1:0] product
);
    logic [2*W-1:0] ext_a;
    logic [2*W-1:0] ext_b;

    always_comb begin
        ext_a = {{W{is_signed & a[W-1]}}, a};
        ext_b = {{W{is_signed & b[W-1]}}, b};
    end

    // The low 2W bits of the extended product are correct in both signed and unsigned forms.
    assign product = ext_a * ext_b;

endmodule

// File: rtl/hilo_combine.sv
module hilo_combine
    import hilo_pkg::*;
#(
    parameter int AW = ACC_W
) (
    input  logic [2:0]    op,
    input  logic [AW-1:0] acc,
    input  logic [AW-1:0] product,
    output logic [AW-1:0] next_acc
);
    always_comb begin
        case (op_kind_e'(op))
            OPK_MUL:  next_acc = product;
            OPK_NMUL: next_acc = '0 - product;
            OPK_MADD: next_acc = acc + product;
            OPK_MSUB: next_acc = acc - product;
            default:  next_acc = acc;
        endcase
    end
endmodule

// File: rtl/hilo_acc_regs.sv
module hilo_acc_regs
    import hilo_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           accept,
    input  logic           want_hi,
    input  logic [2*W-1:0] next_acc,
    input  logic           hi_wr_en,
    input  logic [W-1:0]   hi_wr_data,
    input  logic           lo_wr_en,
    input  logic [W-1:0]   lo_wr_data,
    output logic [W-1:0]   hi_q,
    output logic [W-1:0]   lo_q,
    output logic [W-1:0]   result_q,
    output logic           valid_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q     <= '0;
            lo_q     <= '0;
            result_q <= '0;
            valid_q  <= 1'b0;
        end else begin
            valid_q <= accept;
            if (accept) begin
                hi_q     <= next_acc[2*W-1:W];
                lo_q     <= next_acc[W-1:0];
                result_q <= want_hi ? next_acc[2*W-1:W] : next_acc[W-1:0];
            end else begin
                if (hi_wr_en) hi_q <= hi_wr_data;
                if (lo_wr_en) lo_q <= lo_wr_data;
            end
        end
    end

    // R9
    valid_follows_accept_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> valid_q);
    // R9
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !accept |=> !valid_q);
    // R8
    result_half_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> (result_q == ($past(want_hi) ? hi_q : lo_q)));
    // R7
    split_halves_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> ({hi_q, lo_q} == $past(next_acc)));
    // R10
    hi_write_chk: assert property (@(posedge clk) disable iff (rst)
        (!accept && hi_wr_en) |=> (hi_q == $past(hi_wr_data)));
    // R10
    lo_write_chk: assert property (@(posedge clk) disable iff (rst)
        (!accept && lo_wr_en) |=> (lo_q == $past(lo_wr_data)));
    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!accept && !hi_wr_en && !lo_wr_en) |=> ($stable(hi_q) && $stable(lo_q) && $stable(result_q)));

endmodule

// File: rtl/hilo_mac_top.sv
module hilo_mac_top
    import hilo_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [2:0]  op,
    input  logic        is_signed,
    input  logic        want_hi,
    input  logic [31:0] opa,
    input  logic [31:0] opb,
    input  logic        hi_wr_en,
    input  logic [31:0] hi_wr_data,
    input  logic        lo_wr_en,
    input  logic [31:0] lo_wr_data,
    output logic [31:0] hi_out,
    output logic [31:0] lo_out,
    output logic [31:0] result,
    output logic        result_valid
);
    mac_req_t         req;
    logic             accept;
    logic [ACC_W-1:0] product;
    logic [ACC_W-1:0] next_acc;
    logic [DATA_W-1:0] hi_q;
    logic [DATA_W-1:0] lo_q;

    assign req    = '{op: op, is_signed: is_signed, want_hi: want_hi, a: opa, b: opb};
    assign accept = start && op_is_known(req.op);

    hilo_product #(.W(DATA_W)) u_product (
        .a         (req.a),
        .b         (req.b),
        .is_signed (req.is_signed),
        .product   (product)
    );

    hilo_combine #(.AW(ACC_W)) u_combine (
        .op       (req.op),
        .acc      ({hi_q, lo_q}),
        .product  (product),
        .next_acc (next_acc)
    );

    hilo_acc_regs #(.W(DATA_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .want_hi    (req.want_hi),
        .next_acc   (next_acc),
        .hi_wr_en   (hi_wr_en),
        .hi_wr_data (hi_wr_data),
        .lo_wr_en   (lo_wr_en),
        .lo_wr_data (lo_wr_data),
        .hi_q       (hi_q),
        .lo_q       (lo_q),
        .result_q   (result),
        .valid_q    (result_valid)
    );

    assign hi_out = hi_q;
    assign lo_out = lo_q;

    // R12
    reserved_code_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (start && op[2]) |=> !result_valid);
    // R3
    plain_mul_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && op == 3'd0) |=> ({hi_out, lo_out} == $past(product)));

endmodule

// File: tb/hilo_mac_top_test.sv
module hilo_mac_top_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [2:0]  op;
    logic        is_signed;
    logic        want_hi;
    logic [31:0] opa, opb;
    logic        hi_wr_en, lo_wr_en;
    logic [31:0] hi_wr_data, lo_wr_data;
    logic [31:0] hi_out, lo_out, result;
    logic        result_valid;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    bit [63:0] m_acc;
    bit [31:0] m_result;
    bit        m_valid;
    string     m_tag;

    always #5 clk = ~clk;

    hilo_mac_top uut (
        .clk(clk), .rst(rst), .start(start), .op(op), .is_signed(is_signed),
        .want_hi(want_hi), .opa(opa), .opb(opb),
        .hi_wr_en(hi_wr_en), .hi_wr_data(hi_wr_data),
        .lo_wr_en(lo_wr_en), .lo_wr_data(lo_wr_data),
        .hi_out(hi_out), .lo_out(lo_out), .result(result), .result_valid(result_valid)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural reference: computed from the requirements on integers.
    task automatic model_edge();
        bit [63:0] xa, xb, p;
        if (rst) begin
            m_acc = 0; m_result = 0; m_valid = 0; m_tag = "R1";
            return;
        end
        xa = is_signed ? 64'(signed'(opa)) : {32'd0, opa};
        xb = is_signed ? 64'(signed'(opb)) : {32'd0, opb};
        p  = xa * xb;
        m_valid = 0;
        if (start && op < 3'd4) begin
            case (op)
                3'd0: begin m_acc = p;         m_tag = "R3"; end
                3'd1: begin m_acc = 64'd0 - p; m_tag = "R4"; end
                3'd2: begin m_acc = m_acc + p; m_tag = "R5"; end
                default: begin m_acc = m_acc - p; m_tag = "R6"; end
            endcase
            if (hi_wr_en || lo_wr_en) m_tag = {m_tag, "/R11"};
            m_result = want_hi ? m_acc[63:32] : m_acc[31:0];
            m_valid  = 1;
        end else begin
            m_tag = start ? "R12" : "R10";
            if (hi_wr_en) m_acc[63:32] = hi_wr_data;
            if (lo_wr_en) m_acc[31:0]  = lo_wr_data;
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check({m_tag, " R7 hi"}, 64'(hi_out), 64'(m_acc[63:32]));
        check({m_tag, " R7 lo"}, 64'(lo_out), 64'(m_acc[31:0]));
        check("R9 valid", 64'(result_valid), 64'(m_valid));
        check("R8 result", 64'(result), 64'(m_result));
    endtask

    task automatic idle();
        start = 0; op = 0; is_signed = 0; want_hi = 0; opa = 0; opb = 0;
        hi_wr_en = 0; lo_wr_en = 0; hi_wr_data = 0; lo_wr_data = 0;
    endtask

    task automatic do_op(input logic [2:0] c, input logic s, input logic h,
                         input logic [31:0] a, input logic [31:0] b);
        idle();
        start = 1; op = c; is_signed = s; want_hi = h; opa = a; opb = b;
        step();
        idle();
    endtask

    task automatic wr(input logic he, input logic [31:0] hd, input logic le, input logic [31:0] ld);
        idle();
        hi_wr_en = he; hi_wr_data = hd; lo_wr_en = le; lo_wr_data = ld;
        step();
        idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle();
        rst = 1;
        @(negedge clk);
        step();
        step();
        // R1 reset state
        check("R1 hi", 64'(hi_out), 64'd0);
        check("R1 valid", 64'(result_valid), 64'd0);
        rst = 0;
        step();

        // R2 extension: same operands, signed vs unsigned
        do_op(3'd0, 1'b1, 1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF);
        check("R2 signed hi", 64'({hi_out, lo_out}), 64'h0000000000000001);
        do_op(3'd0, 1'b0, 1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF);
        check("R2 unsigned", 64'({hi_out, lo_out}), 64'hFFFFFFFE00000001);
        check("R8 hi returned", 64'(result), 64'hFFFFFFFE);
        step();
        check("R9 single pulse", 64'(result_valid), 64'd0);
        check("R8 result held", 64'(result), 64'hFFFFFFFE);

        // R3 signed mul -3*5
        do_op(3'd0, 1'b1, 1'b0, 32'hFFFFFFFD, 32'd5);
        check("R3 mul", 64'({hi_out, lo_out}), 64'hFFFFFFFFFFFFFFF1);
        check("R8 lo returned", 64'(result), 64'hFFFFFFF1);
        // R4 negated
        do_op(3'd1, 1'b0, 1'b1, 32'd7, 32'd6);
        check("R4 neg", 64'({hi_out, lo_out}), 64'hFFFFFFFFFFFFFFD6);
        // R5 accumulate across wrap: acc = -42, add 50
        do_op(3'd2, 1'b0, 1'b1, 32'd10, 32'd5);
        check("R5 wrap", 64'({hi_out, lo_out}), 64'd8);
        check("R5 hi result", 64'(result), 64'd0);
        // R6 subtract below zero
        do_op(3'd3, 1'b1, 1'b0, 32'd3, 32'd3);
        check("R6 borrow", 64'({hi_out, lo_out}), 64'hFFFFFFFFFFFFFFFF);

        // R10 independent writes
        wr(1'b1, 32'h12345678, 1'b0, 32'hDEADBEEF);
        check("R10 hi only", 64'({hi_out, lo_out}), 64'h12345678FFFFFFFF);
        wr(1'b0, 32'h0, 1'b1, 32'h0BADF00D);
        check("R10 lo only", 64'({hi_out, lo_out}), 64'h123456780BADF00D);

        // R11 operation beats write
        idle();
        start = 1; op = 3'd0; opa = 32'd2; opb = 32'd3;
        hi_wr_en = 1; hi_wr_data = 32'hAAAAAAAA; lo_wr_en = 1; lo_wr_data = 32'h55555555;
        step();
        idle();
        check("R11 op wins", 64'({hi_out, lo_out}), 64'd6);

        // R12 reserved code ignored, write in same cycle applies
        do_op(3'd5, 1'b0, 1'b1, 32'd9, 32'd9);
        check("R12 no pulse", 64'(result_valid), 64'd0);
        check("R12 hold", 64'({hi_out, lo_out}), 64'd6);
        idle();
        start = 1; op = 3'd7; lo_wr_en = 1; lo_wr_data = 32'h00C0FFEE;
        step();
        idle();
        check("R12 write applies", 64'(lo_out), 64'h00C0FFEE);

        // Random run against the model
        for (int i = 0; i < 400; i++) begin
            start      = ($urandom % 4) != 0;
            op         = 3'($urandom % 6);
            is_signed  = 1'($urandom);
            want_hi    = 1'($urandom);
            opa        = $urandom;
            opb        = (i % 7 == 0) ? 32'hFFFFFFFF : $urandom;
            hi_wr_en   = ($urandom % 5) == 0;
            lo_wr_en   = ($urandom % 5) == 0;
            hi_wr_data = $urandom;
            lo_wr_data = $urandom;
            step();
        end
        idle();
        step();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule